// File: doc/BRIEF.md
# LED Driver Power Sequencer

This block decides when a switching LED driver is awake and how its boost stage comes up. It runs on a fixed system clock. It watches a single input line that both enables the device and carries the PWM dimming waveform. A high pulse on that line that lasts long enough wakes the device. The block then asserts the regulator enable and waits until both supply-good flags report good. After that it ramps a switch current-limit code in equal steps over a fixed soft-start period. The ramp ends early if the feedback reaches three quarters of its target. In the run state the gate enable and the dimming output follow the input line. The block returns to shutdown once the line has stayed low for a long, parameterised time.

The input line passes through a two-flop synchronizer before any decision is taken on it. All timings are clock-cycle counts given as parameters. The soft-start period is `SS_TOTAL_CYC`, the wake qualification is `WAKE_CYC`, and the inactivity limit is `IDLE_CYC`. The step length is derived as `SS_TOTAL_CYC / (2**ILIM_W - 1)`. In this brief, MAX denotes the full current-limit code `2**ILIM_W - 1`.

States and transitions:
- **SHUTDOWN**: goes to WAKE_QUALIFY when the synchronized line is high.
- **WAKE_QUALIFY**: goes back to SHUTDOWN if the line falls. It goes to WAIT_SUPPLY once the line has been held long enough.
- **WAIT_SUPPLY**: goes to SOFT_START when both supply flags are good.
- **SOFT_START**: goes to RUN when the ramp completes or the feedback flag is set. It goes back to WAIT_SUPPLY if a supply flag drops.
- **RUN**: goes back to WAIT_SUPPLY if a supply flag drops.
- **Inactivity expiry**: in any of WAIT_SUPPLY, SOFT_START and RUN, expiry of the inactivity timer leads to SHUTDOWN. This has the highest priority.

Top module: `led_power_seq`

## Requirements
- R1: After reset the state is SHUTDOWN. In that state `reg_en`, `gate_en` and `dim_out` are 0 and `ilim_code` is 0.
- R2: A high pulse on `dim_in` lasting `WAKE_CYC+1` or more clock cycles wakes the device, and a shorter pulse does not. With the line held high, the state becomes WAIT_SUPPLY on the `WAKE_CYC+3`-th rising edge after the input rises.
- R3: `reg_en` is 1 in WAIT_SUPPLY, SOFT_START and RUN, and 0 in SHUTDOWN and WAKE_QUALIFY. WAIT_SUPPLY moves to SOFT_START on the next edge only once `vdr_good` and `ldo_good` are both 1.
- R4: Soft-start starts with `ilim_code` at 0 and adds one every step length. It lasts exactly `SS_TOTAL_CYC` cycles (MAX times the step length) and then enters RUN with `ilim_code` at MAX.
- R5: If `fb_75pct` is 1 during SOFT_START, the next edge enters RUN with `ilim_code` at MAX.
- R6: When `dim_in` stays low for `IDLE_CYC` or more cycles, the state reaches SHUTDOWN `IDLE_CYC+2` edges after the fall, with `reg_en` at 0. A low stretch of `IDLE_CYC-1` cycles leaves the device awake, because each low stretch restarts the timer.
- R7: In RUN, `gate_en` and `dim_out` equal the input line delayed by the two synchronizer cycles. `gate_en` behaves the same way in SOFT_START. `dim_out` is 0 in every state other than RUN.
- R8: While `adim_low` is 1, `gate_en` and `dim_out` are 0 in the same cycle. When it clears, the outputs follow again with the state still RUN and `ilim_code` still at MAX, so no new soft-start takes place.
- R9: If either supply flag drops in SOFT_START or RUN, the next edge enters WAIT_SUPPLY with `gate_en`, `dim_out` and `ilim_code` at 0. Soft-start restarts from code 0 when both flags return.
- R10: The `state_o` encoding is SHUTDOWN=0, WAKE_QUALIFY=1, WAIT_SUPPLY=2, SOFT_START=3 and RUN=4. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dim_in | input | 1 | Combined enable and PWM dimming line (asynchronous) |
| vdr_good | input | 1 | Gate-driver supply above its upper threshold |
| ldo_good | input | 1 | Core supply above its upper threshold |
| fb_75pct | input | 1 | Feedback has reached 75% of its nominal value |
| adim_low | input | 1 | Analog dimming voltage below its off threshold |
| reg_en | output | 1 | Regulator enable |
| gate_en | output | 1 | Boost switching enable |
| dim_out | output | 1 | Buffered dimming output |
| ilim_code | output | ILIM_W | Switch current-limit code |
| state_o | output | 3 | Sequencer state |

## Verification
The bound checker checks the following properties on every cycle:
- SHUTDOWN is quiet.
- The state encoding stays legal.
- SHUTDOWN can only lead to wake qualification.
- WAIT_SUPPLY is held while the supplies are bad.
- A supply drop leaves SOFT_START and RUN.
- The ramp never moves by more than one code per cycle.
- The feedback flag ends soft-start.
- The analog-dim flag forces the outputs off.
- `dim_out` is confined to RUN.

Some behaviour only the bench scenarios can show:
- The exact wake-pulse length threshold, found by sweeping the pulse length.
- The exact lengths of soft-start and of the inactivity window.
- The two-cycle latency of the dimming path.
- That the timer restarts on each low stretch.
- That a cleared analog-dim flag resumes without a new ramp.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [2:0] {
        SEQ_SHUTDOWN     = 3'd0,
        SEQ_WAKE_QUALIFY = 3'd1,
        SEQ_WAIT_SUPPLY  = 3'd2,
        SEQ_SOFT_START   = 3'd3,
        SEQ_RUN          = 3'd4
    } seq_state_t;
endpackage

// File: rtl/ssq_sync.sv
module ssq_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/ssq_idle_timer.sv
module ssq_idle_timer #(
    parameter int IDLE_CYC = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic line_hi,
    output logic expired
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    logic [CW-1:0] low_cnt;

    // Counts consecutive low cycles; any high cycle or disarm restarts it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!armed || line_hi) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(IDLE_CYC - 1)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign expired = armed && !line_hi && (low_cnt == CW'(IDLE_CYC - 1));
endmodule

// File: rtl/ssq_ramp.sv
module ssq_ramp #(
    parameter int ILIM_W  = 4,
    parameter int STEP_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    output logic [ILIM_W-1:0] code,
    output logic              done
);
    localparam int                SW       = $clog2(STEP_CYC + 1);
    localparam logic [ILIM_W-1:0] CODE_MAX = {ILIM_W{1'b1}};

    logic [SW-1:0] step_cnt;
    logic          step_end;

    assign step_end = (step_cnt == SW'(STEP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
            code     <= '0;
        end else if (!active) begin
            step_cnt <= '0;
            code     <= '0;
        end else if (step_end) begin
            step_cnt <= '0;
            if (code != CODE_MAX) begin
                code <= code + 1'b1;
            end
        end else begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    assign done = active && step_end && (code == CODE_MAX - 1'b1);
endmodule

// File: rtl/led_power_seq.sv
module led_power_seq
    import ssq_pkg::*;
#(
    parameter int WAKE_CYC     = 25000,
    parameter int IDLE_CYC     = 2500000,
    parameter int SS_TOTAL_CYC = 750000,
    parameter int ILIM_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dim_in,
    input  logic              vdr_good,
    input  logic              ldo_good,
    input  logic              fb_75pct,
    input  logic              adim_low,
    output logic              reg_en,
    output logic              gate_en,
    output logic              dim_out,
    output logic [ILIM_W-1:0] ilim_code,
    output logic [2:0]        state_o
);
    localparam int                ILIM_MAX = (1 << ILIM_W) - 1;
    localparam int                STEP_CYC = SS_TOTAL_CYC / ILIM_MAX;
    localparam int                QW       = $clog2(WAKE_CYC + 1);
    localparam logic [ILIM_W-1:0] CODE_MAX = {ILIM_W{1'b1}};

    seq_state_t        state, state_nx;
    logic              line_s;
    logic              rails_ok;
    logic              idle_exp;
    logic              ramp_done;
    logic [ILIM_W-1:0] ramp_code;
    logic [QW-1:0]     qual_cnt;
    logic              awake;

    ssq_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (dim_in),
        .d_sync  (line_s)
    );

    assign awake = (state == SEQ_WAIT_SUPPLY) || (state == SEQ_SOFT_START) ||
                   (state == SEQ_RUN);

    ssq_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (awake),
        .line_hi (line_s),
        .expired (idle_exp)
    );

    ssq_ramp #(.ILIM_W(ILIM_W), .STEP_CYC(STEP_CYC)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == SEQ_SOFT_START),
        .code   (ramp_code),
        .done   (ramp_done)
    );

    assign rails_ok = vdr_good && ldo_good;

    // Wake qualification counter, live only in WAKE_QUALIFY.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_cnt <= '0;
        end else if (state == SEQ_WAKE_QUALIFY && line_s) begin
            qual_cnt <= qual_cnt + 1'b1;
        end else begin
            qual_cnt <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_SHUTDOWN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_SHUTDOWN: begin
                if (line_s) state_nx = SEQ_WAKE_QUALIFY;
            end
            SEQ_WAKE_QUALIFY: begin
                if (!line_s)                          state_nx = SEQ_SHUTDOWN;
                else if (qual_cnt == QW'(WAKE_CYC-1)) state_nx = SEQ_WAIT_SUPPLY;
            end
            SEQ_WAIT_SUPPLY: begin
                if (idle_exp)      state_nx = SEQ_SHUTDOWN;
                else if (rails_ok) state_nx = SEQ_SOFT_START;
            end
            SEQ_SOFT_START: begin
                if (idle_exp)                   state_nx = SEQ_SHUTDOWN;
                else if (!rails_ok)             state_nx = SEQ_WAIT_SUPPLY;
                else if (ramp_done || fb_75pct) state_nx = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (idle_exp)       state_nx = SEQ_SHUTDOWN;
                else if (!rails_ok) state_nx = SEQ_WAIT_SUPPLY;
            end
            default: state_nx = SEQ_SHUTDOWN;
        endcase
    end

    always_comb begin
        reg_en    = 1'b0;
        gate_en   = 1'b0;
        dim_out   = 1'b0;
        ilim_code = '0;
        unique case (state)
            SEQ_SHUTDOWN, SEQ_WAKE_QUALIFY: begin
            end
            SEQ_WAIT_SUPPLY: begin
                reg_en = 1'b1;
            end
            SEQ_SOFT_START: begin
                reg_en    = 1'b1;
                gate_en   = line_s && !adim_low;
                ilim_code = ramp_code;
            end
            SEQ_RUN: begin
                reg_en    = 1'b1;
                gate_en   = line_s && !adim_low;
                dim_out   = line_s && !adim_low;
                ilim_code = CODE_MAX;
            end
            default: begin
            end
        endcase
    end

    assign state_o = state;
endmodule

// File: rtl/led_power_seq_chk.sv
module led_power_seq_chk
    import ssq_pkg::*;
#(
    parameter int ILIM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vdr_good,
    input logic              ldo_good,
    input logic              fb_75pct,
    input logic              adim_low,
    input logic              reg_en,
    input logic              gate_en,
    input logic              dim_out,
    input logic [ILIM_W-1:0] ilim_code,
    input logic [2:0]        state_o
);
    localparam logic [ILIM_W-1:0] CODE_MAX = {ILIM_W{1'b1}};

    AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SEQ_SHUTDOWN) |-> (!reg_en && !gate_en && !dim_out && ilim_code == '0)); // R1

    AST_SHUTDOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SEQ_SHUTDOWN) |=> (state_o == SEQ_SHUTDOWN || state_o == SEQ_WAKE_QUALIFY)); // R2

    AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SEQ_WAIT_SUPPLY && !(vdr_good && ldo_good))
        |=> (state_o == SEQ_WAIT_SUPPLY || state_o == SEQ_SHUTDOWN)); // R3

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SEQ_SOFT_START) ##1 (state_o == SEQ_SOFT_START)
        |-> (ilim_code == $past(ilim_code) || ilim_code == ILIM_W'($past(ilim_code) + 1'b1))); // R4

    AST_RAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SEQ_SOFT_START) ##1 (state_o == SEQ_RUN) |-> (ilim_code == CODE_MAX)); // R4

    AST_FB_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == SEQ_SOFT_START && fb_75pct) |=> (state_o != SEQ_SOFT_START)); // R5

    AST_DIM_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dim_out |-> (state_o == SEQ_RUN)); // R7

    AST_ADIM_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        adim_low |-> (!gate_en && !dim_out)); // R8

    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == SEQ_SOFT_START || state_o == SEQ_RUN) && !(vdr_good && ldo_good))
        |=> (state_o == SEQ_WAIT_SUPPLY || state_o == SEQ_SHUTDOWN)); // R9

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o <= 3'd4)); // R10
endmodule

bind led_power_seq led_power_seq_chk #(.ILIM_W(ILIM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vdr_good  (vdr_good),
    .ldo_good  (ldo_good),
    .fb_75pct  (fb_75pct),
    .adim_low  (adim_low),
    .reg_en    (reg_en),
    .gate_en   (gate_en),
    .dim_out   (dim_out),
    .ilim_code (ilim_code),
    .state_o   (state_o)
);

// File: tb/sim_led_power_seq.sv
module sim_led_power_seq;
    localparam int WAKE  = 6;
    localparam int IDLE  = 30;
    localparam int SST   = 21;
    localparam int W     = 3;
    localparam int MAXC  = (1 << W) - 1;
    localparam int STEP  = SST / MAXC;
    localparam int S_SHD = 0, S_WQ = 1, S_WS = 2, S_SS = 3, S_RUN = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dim_in = 1'b0, vdr_good = 1'b0, ldo_good = 1'b0;
    logic         fb_75pct = 1'b0, adim_low = 1'b0;
    logic         reg_en, gate_en, dim_out;
    logic [W-1:0] ilim_code;
    logic [2:0]   state_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    led_power_seq #(.WAKE_CYC(WAKE), .IDLE_CYC(IDLE), .SS_TOTAL_CYC(SST), .ILIM_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .dim_in(dim_in), .vdr_good(vdr_good),
        .ldo_good(ldo_good), .fb_75pct(fb_75pct), .adim_low(adim_low),
        .reg_en(reg_en), .gate_en(gate_en), .dim_out(dim_out),
        .ilim_code(ilim_code), .state_o(state_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        int bad;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 / R10: reset state
        chk(state_o == S_SHD, "R1 state", state_o, S_SHD);
        chk({reg_en, gate_en, dim_out} == 3'b000 && ilim_code == 0, "R1 outputs",
            {reg_en, gate_en, dim_out, ilim_code}, 0);

        // R2 sweep of wake pulse lengths, supplies low
        for (int len = 1; len <= WAKE + 3; len++) begin
            bit woke = 0;
            bad = 0;
            dim_in = 1'b1;
            for (int t = 0; t < len; t++) begin
                tick();
                if (state_o == S_WS) woke = 1;
                if (state_o == S_WQ && reg_en) bad++;
                if (state_o == S_SS) bad++;
            end
            dim_in = 1'b0;
            for (int t = 0; t < IDLE + 12; t++) begin
                tick();
                if (state_o == S_WS) woke = 1;
                if (state_o == S_WQ && reg_en) bad++;
                if (state_o == S_SS) bad++;
            end
            chk(woke == (len >= WAKE + 1), "R2 pulse qualify", woke, len >= WAKE + 1);
            chk(bad == 0, "R3 no enable in qualify / no start without supply", bad, 0);
            chk(state_o == S_SHD, "R6 back to shutdown", state_o, S_SHD);
        end

        // R2 exact wake latency
        dim_in = 1'b1;
        n = 0;
        do begin tick(); n++; end while (state_o != S_WS && n < 100);
        chk(n == WAKE + 3, "R2 wake latency", n, WAKE + 3);
        chk(reg_en == 1'b1, "R3 reg_en in WAIT_SUPPLY", reg_en, 1);
        repeat (10) tick();
        chk(state_o == S_WS, "R3 wait without supplies", state_o, S_WS);
        vdr_good = 1'b1;
        repeat (5) tick();
        chk(state_o == S_WS, "R3 wait with one supply", state_o, S_WS);
        ldo_good = 1'b1;
        tick();
        chk(state_o == S_SS, "R3 start on both supplies", state_o, S_SS);

        // R4 ramp profile
        n = 0;
        bad = 0;
        while (state_o == S_SS && n < 200) begin
            if (ilim_code != n / STEP) bad++;
            if (gate_en != 1'b1) bad++;
            tick();
            n++;
        end
        chk(bad == 0, "R4 ramp codes / R7 gate in soft-start", bad, 0);
        chk(n == MAXC * STEP, "R4 soft-start length", n, MAXC * STEP);
        chk(state_o == S_RUN && ilim_code == MAXC, "R4 run at full code", ilim_code, MAXC);

        // R7 follow with two-cycle latency
        begin
            logic [9:0] pat = 10'b1011001110;
            logic prev = 1'b1;
            for (int i = 9; i >= 0; i--) begin
                dim_in = pat[i];
                tick();
                chk(gate_en == prev && dim_out == prev, "R7 one cycle old", gate_en, prev);
                tick();
                chk(gate_en == pat[i] && dim_out == pat[i], "R7 follow", dim_out, pat[i]);
                prev = pat[i];
            end
        end
        dim_in = 1'b1;
        repeat (2) tick();

        // R8 analog dim low
        adim_low = 1'b1;
        #1;
        chk(!gate_en && !dim_out, "R8 forced low", {gate_en, dim_out}, 0);
        tick();
        chk(state_o == S_RUN, "R8 state held", state_o, S_RUN);
        adim_low = 1'b0;
        #1;
        chk(gate_en && dim_out && ilim_code == MAXC && state_o == S_RUN,
            "R8 resume without soft-start", ilim_code, MAXC);
        tick();

        // R6 timer restart on each low stretch
        for (int k = 0; k < 3; k++) begin
            dim_in = 1'b0;
            repeat (IDLE - 1) tick();
            dim_in = 1'b1;
            repeat (3) tick();
        end
        chk(state_o == S_RUN, "R6 short lows stay awake", state_o, S_RUN);

        // R9 supply loss
        ldo_good = 1'b0;
        tick();
        chk(state_o == S_WS, "R9 back to wait", state_o, S_WS);
        chk(!gate_en && !dim_out && ilim_code == 0 && reg_en, "R9 outputs low",
            {gate_en, dim_out, ilim_code}, 0);
        ldo_good = 1'b1;
        tick();
        chk(state_o == S_SS && ilim_code == 0, "R9 soft-start repeats", ilim_code, 0);

        // R5 early finish
        repeat (4) tick();
        chk(state_o == S_SS && ilim_code == 4 / STEP, "R5 ramp in progress", ilim_code, 4 / STEP);
        fb_75pct = 1'b1;
        tick();
        chk(state_o == S_RUN && ilim_code == MAXC, "R5 early run", ilim_code, MAXC);
        fb_75pct = 1'b0;
        tick();

        // R6 inactivity shutdown
        dim_in = 1'b0;
        n = 0;
        do begin tick(); n++; end while (state_o != S_SHD && n < IDLE + 50);
        chk(n == IDLE + 2, "R6 idle window", n, IDLE + 2);
        chk(reg_en == 1'b0, "R6 regulators off", reg_en, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule